// File: doc/BRIEF.md
# Cascadable Line Loader for Column Gray Codes

This block collects one display line of gray codes into a flat line buffer. Each transfer presents six parallel buses at once, and each bus carries one code. The six codes fill six neighbouring columns, called a group. Several loaders are chained, and each hands an enable token to the next one when it has finished. A loader sits idle until the token arrives on its input-side token pin. It then walks a group pointer across the line, writing one group per clock or two per clock. After the final group it pulses the token on the opposite pin, so that the next loader in the chain starts.

A direction input picks the fill order and, with it, which token pin listens and which one drives. A mode input picks single-edge capture (falling edge only) or dual-edge capture (falling and rising edges). Two invert controls each complement three of the six buses before the data is stored. The finished line is presented as one flat vector for the stage that follows.

Top module: `column_loader`

## Requirements
- R1: After reset, `busy_o` is 0, both token outputs are 0 and every bit of `line_o` is 0.
- R2: While idle, a 1 on the input-side token pin at a rising clock edge raises `busy_o` from the next cycle on. With `dir_up_i`=1 the input-side pin is `tok_a_i`; with `dir_up_i`=0 it is `tok_b_i`. A 1 on the other pin is ignored.
- R3: With `dir_up_i`=1, groups are written in ascending order, from group 0 to group NCOL/6-1. The token leaves on `tok_b_o`, and `tok_a_o` stays 0.
- R4: With `dir_up_i`=0, groups are written in descending order, from group NCOL/6-1 to group 0. The token leaves on `tok_a_o`, and `tok_b_o` stays 0.
- R5: Within group g, bus A lands in column 6g, B in 6g+1, C in 6g+2, D in 6g+3, E in 6g+4 and F in 6g+5. Column c occupies `line_o[6c+5:6c]`.
- R6: With `sedge_i`=1, each rising edge while busy writes one group. The data written is the value the buses held at the falling edge just before that rising edge.
- R7: With `sedge_i`=0, each rising edge while busy writes two groups. The falling-edge data goes to the current group. The data present at the rising edge goes to the group after it in fill order. For this mode, NCOL must be a multiple of 12.
- R8: A 1 on `inv_abc_i` complements buses A, B and C before storage. A 1 on `inv_def_i` complements D, E and F. The two controls act independently.
- R9: The edge that writes the final group also drops `busy_o` and raises the output-side token pin for exactly one cycle.
- R10: While idle, bus activity leaves `line_o` unchanged. A token that arrives while busy does not restart the fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transfer clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dir_up_i | input | 1 | 1: ascending fill, token enters on A; 0: descending fill, token enters on B |
| sedge_i | input | 1 | 1: falling-edge capture only; 0: capture on both edges |
| inv_abc_i | input | 1 | Complement buses A, B, C |
| inv_def_i | input | 1 | Complement buses D, E, F |
| bus_a_i | input | BITS | Code for column 6g |
| bus_b_i | input | BITS | Code for column 6g+1 |
| bus_c_i | input | BITS | Code for column 6g+2 |
| bus_d_i | input | BITS | Code for column 6g+3 |
| bus_e_i | input | BITS | Code for column 6g+4 |
| bus_f_i | input | BITS | Code for column 6g+5 |
| tok_a_i | input | 1 | Token pin A, listened to when ascending |
| tok_b_i | input | 1 | Token pin B, listened to when descending |
| tok_a_o | output | 1 | Token pin A, driven when descending |
| tok_b_o | output | 1 | Token pin B, driven when ascending |
| busy_o | output | 1 | Fill in progress |
| line_o | output | NCOL*BITS | Flat line buffer |

## Verification
The bench builds the loader with NCOL=48 and BITS=6, which gives eight groups. A whole fill is then a handful of cycles, so every direction, capture mode and invert setting can be run to completion and its token pulse observed. The buffer is compared after every write, so the fill order and the falling-before-rising pairing of dual-edge mode are checked group by group, not only at the end.

// File: rtl/column_loader.sv
module column_loader #(
  parameter int NCOL = 384,
  parameter int BITS = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 dir_up_i,
  input  logic                 sedge_i,
  input  logic                 inv_abc_i,
  input  logic                 inv_def_i,
  input  logic [BITS-1:0]      bus_a_i,
  input  logic [BITS-1:0]      bus_b_i,
  input  logic [BITS-1:0]      bus_c_i,
  input  logic [BITS-1:0]      bus_d_i,
  input  logic [BITS-1:0]      bus_e_i,
  input  logic [BITS-1:0]      bus_f_i,
  input  logic                 tok_a_i,
  input  logic                 tok_b_i,
  output logic                 tok_a_o,
  output logic                 tok_b_o,
  output logic                 busy_o,
  output logic [NCOL*BITS-1:0] line_o
);
  localparam int NGRP = NCOL / 6;
  localparam int GW   = 6 * BITS;
  localparam int PW   = (NGRP > 1) ? $clog2(NGRP) : 1;
  localparam logic [PW-1:0] LAST = PW'(NGRP - 1);
  localparam logic [PW-1:0] ONE  = PW'(1);
  localparam logic [PW-1:0] TWO  = PW'(2);

  logic [GW-1:0]        grp_in, fall_q;
  logic [NCOL*BITS-1:0] line_q;
  logic [PW-1:0]        ptr_q, ptr_nx, ptr_nx2;
  logic                 busy_q, up_q, tok_q, tok_in, last_wr;
  logic [BITS-1:0]      m_abc, m_def;

  assign m_abc  = {BITS{inv_abc_i}};
  assign m_def  = {BITS{inv_def_i}};
  assign grp_in = {bus_f_i ^ m_def, bus_e_i ^ m_def, bus_d_i ^ m_def,
                   bus_c_i ^ m_abc, bus_b_i ^ m_abc, bus_a_i ^ m_abc};

  assign tok_in  = dir_up_i ? tok_a_i : tok_b_i;
  assign ptr_nx  = up_q ? ptr_q + ONE : ptr_q - ONE;
  assign ptr_nx2 = up_q ? ptr_q + TWO : ptr_q - TWO;
  assign last_wr = sedge_i ? (ptr_q == (up_q ? LAST : '0))
                           : (ptr_q == (up_q ? LAST - ONE : ONE));

  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) fall_q <= '0;
    else        fall_q <= grp_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      up_q   <= 1'b1;
      tok_q  <= 1'b0;
      ptr_q  <= '0;
      line_q <= '0;
    end else begin
      tok_q <= 1'b0;
      if (!busy_q) begin
        if (tok_in) begin
          busy_q <= 1'b1;
          up_q   <= dir_up_i;
          ptr_q  <= dir_up_i ? '0 : LAST;
        end
      end else begin
        line_q[ptr_q*GW +: GW] <= fall_q;
        if (!sedge_i) line_q[ptr_nx*GW +: GW] <= grp_in;
        if (last_wr) begin
          busy_q <= 1'b0;
          tok_q  <= 1'b1;
        end else begin
          ptr_q <= sedge_i ? ptr_nx : ptr_nx2;
        end
      end
    end
  end

  assign tok_a_o = tok_q & ~up_q;
  assign tok_b_o = tok_q & up_q;
  assign busy_o  = busy_q;
  assign line_o  = line_q;

  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && tok_in) |=> busy_q);
  assert_ptr_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (int'(ptr_q) < NGRP));
  assert_tok_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_a_o || tok_b_o) |-> (!busy_q && $past(busy_q)));
  assert_tok_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_a_o || tok_b_o) |=> !(tok_a_o || tok_b_o));
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |=> $stable(line_q));
  assert_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last_wr) |=> busy_q);
endmodule

// File: tb/column_loader_tb_top.sv
module column_loader_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCOL = 48;
  localparam int BITS = 6;
  localparam int NGRP = NCOL / 6;

  logic clk = 0, rst_n = 0;
  logic dir_up = 1, sedge = 1, inv_abc = 0, inv_def = 0;
  logic [BITS-1:0] bus [6];
  logic tok_a_i = 0, tok_b_i = 0;
  logic tok_a_o, tok_b_o, busy;
  logic [NCOL*BITS-1:0] line, exp_line;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  column_loader #(.NCOL(NCOL), .BITS(BITS)) dut_i (
    .clk(clk), .rst_n(rst_n), .dir_up_i(dir_up), .sedge_i(sedge),
    .inv_abc_i(inv_abc), .inv_def_i(inv_def),
    .bus_a_i(bus[0]), .bus_b_i(bus[1]), .bus_c_i(bus[2]),
    .bus_d_i(bus[3]), .bus_e_i(bus[4]), .bus_f_i(bus[5]),
    .tok_a_i(tok_a_i), .tok_b_i(tok_b_i), .tok_a_o(tok_a_o), .tok_b_o(tok_b_o),
    .busy_o(busy), .line_o(line));

  task automatic chk(input bit ok, input string req, input logic [NCOL*BITS-1:0] act,
                     input logic [NCOL*BITS-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [BITS-1:0] raw(input int c, input int seed);
    return BITS'((c * 5 + seed) % 64);
  endfunction

  function automatic logic [BITS-1:0] stored(input int c, input int seed);
    logic [BITS-1:0] m;
    m = ((c % 6) < 3) ? {BITS{inv_abc}} : {BITS{inv_def}};
    return raw(c, seed) ^ m;
  endfunction

  task automatic drive_grp(input int g, input int seed);
    for (int k = 0; k < 6; k++) bus[k] = raw(6 * g + k, seed);
  endtask

  task automatic put_exp(input int g, input int seed);
    for (int k = 0; k < 6; k++) exp_line[(6 * g + k) * BITS +: BITS] = stored(6 * g + k, seed);
  endtask

  // Full fill: R3/R4 order, R5 mapping, R6/R7 capture, R8 invert, R9 token; optional R10 busy token
  task automatic run_fill(input bit up, input bit single, input bit ia, input bit id,
                          input int seed, input bit poke_busy, input string tag);
    int steps, fg, rg;
    dir_up = up; sedge = single; inv_abc = ia; inv_def = id;
    steps = single ? NGRP : NGRP / 2;
    exp_line = line;
    @(posedge clk); #2;
    if (up) tok_a_i = 1; else tok_b_i = 1;
    @(posedge clk); #1;
    chk(busy === 1'b1, {tag, " R2 busy after token"}, busy, 1);
    #1; tok_a_i = 0; tok_b_i = 0;
    fg = single ? (up ? 0 : NGRP - 1) : (up ? 0 : NGRP - 1);
    drive_grp(fg, seed);
    if (!single) begin #5; drive_grp(up ? 1 : NGRP - 2, seed); end
    for (int s = 0; s < steps; s++) begin
      @(posedge clk); #1;
      if (single) fg = up ? s : NGRP - 1 - s;
      else begin fg = up ? 2 * s : NGRP - 1 - 2 * s; rg = up ? fg + 1 : fg - 1; end
      put_exp(fg, seed);
      if (!single) put_exp(rg, seed);
      chk(line === exp_line, {tag, up ? " R3 R5 R8 order" : " R4 R5 R8 order",
          single ? " R6" : " R7"}, line, exp_line);
      if (s < steps - 1) begin
        chk(busy === 1'b1 && tok_a_o === 0 && tok_b_o === 0, {tag, " R9 busy mid-fill"},
            {busy, tok_a_o, tok_b_o}, 3'b100);
        #1;
        if (poke_busy && s == 1) begin if (up) tok_a_i = 1; else tok_b_i = 1; end
        else begin tok_a_i = 0; tok_b_i = 0; end
        if (single) fg = up ? s + 1 : NGRP - 2 - s;
        else fg = up ? 2 * s + 2 : NGRP - 3 - 2 * s;
        drive_grp(fg, seed);
        if (!single) begin #5; drive_grp(up ? fg + 1 : fg - 1, seed); end
      end
    end
    chk(busy === 0 && tok_a_o === !up && tok_b_o === up,
        {tag, up ? " R9 R3 token out B" : " R9 R4 token out A"},
        {busy, tok_a_o, tok_b_o}, {1'b0, !up, up});
    @(posedge clk); #1;
    chk(tok_a_o === 0 && tok_b_o === 0 && busy === 0, {tag, " R9 one-cycle pulse"},
        {busy, tok_a_o, tok_b_o}, 0);
    tok_a_i = 0; tok_b_i = 0;
  endtask

  task automatic t_reset;
    #1;
    chk(busy === 0 && tok_a_o === 0 && tok_b_o === 0, "R1 reset flags", {busy, tok_a_o, tok_b_o}, 0);
    chk(line === '0, "R1 reset line", line, 0);
  endtask

  task automatic t_idle_ignore;
    exp_line = line;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #2; drive_grp(i, 17 + i);
    end
    @(posedge clk); #1;
    chk(line === exp_line && busy === 0, "R10 idle bus ignored", line, exp_line);
  endtask

  task automatic t_wrong_pin;
    dir_up = 1;
    @(posedge clk); #2; tok_b_i = 1;
    @(posedge clk); #1;
    chk(busy === 0, "R2 wrong pin ignored (up)", busy, 0);
    #1; tok_b_i = 0; dir_up = 0; tok_a_i = 1;
    @(posedge clk); #1;
    chk(busy === 0, "R2 wrong pin ignored (down)", busy, 0);
    #1; tok_a_i = 0;
  endtask

  bit finished = 0;
  initial begin
    for (int k = 0; k < 6; k++) bus[k] = '0;
    #(CLK_PERIOD * 2 + 2);
    t_reset();
    rst_n = 1;
    t_wrong_pin();
    run_fill(1, 1, 0, 0, 3,  0, "up-single");
    t_idle_ignore();
    run_fill(0, 1, 1, 0, 11, 0, "down-single-invabc");
    run_fill(1, 0, 0, 1, 23, 0, "up-dual-invdef");
    run_fill(0, 0, 1, 1, 41, 0, "down-dual-invall");
    run_fill(1, 1, 0, 0, 7,  1, "up-single-R10-busytoken");
    run_fill(0, 0, 0, 0, 9,  1, "down-dual-R10-busytoken");
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule